// File: doc/BRIEF.md
# Vector Fixed-Point Multiply Unit

This unit runs the multiply group of a vector coprocessor. One 32-bit instruction word names two source registers, a destination register, an element count, a product width, a post-shift and a rounding request. After the word is accepted, the unit steps through consecutive registers, one element per clock. For each element it forms a signed product, shifts it right with optional round-to-nearest, and writes the result back to its own 128-entry, 32-bit register file.

There are three forms. Element-wise multiply writes one result per element. Dot product adds up the element results and writes one sum. Scaled add multiplies each A element by a scalar taken from register 1, then adds the matching B element. A host port can load and read the register file, so the unit can be tested without a surrounding core. Instruction fetch and queueing sit outside the block.

Top module: `vmul_unit`

## Requirements
- R1: The top nibble of the word (bits 31..28) selects the product. Codes 0, 1 and 2 give a signed 16x16 product: low half of A times low half of the multiplier. Codes 4, 5 and 6 give a signed 32x16 product: all of A times the low half of the multiplier. The low two bits of the code set the post-shift: 0 gives 0, 1 gives 8, 2 gives 16 bits (arithmetic right shift). The result is the low 32 bits.
- R2: When bit 23 is set and the shift is not zero, 2^(shift-1) is added to the product before the shift. With a shift of 0, bit 23 has no effect.
- R3: Bits 22..21 = 0 is element-wise multiply. The element count is the value in bits 27..24 plus one. Element i writes register D+i with the result for registers A+i and B+i (A in bits 20..14, D in bits 13..7, B in bits 6..0). Writes come on consecutive cycles, the first in the cycle after acceptance.
- R4: Bits 22..21 = 1 is dot product. The element results are added modulo 2^32. The sum is written once, to register D, in the cycle of the last element.
- R5: Bits 22..21 = 2 is scaled add. Element i writes D+i with the shifted product of register A+i and register 1, plus register B+i.
- R6: Register 0 always reads as zero. Writes to it from the unit or from the host are dropped.
- R7: `busy` rises in the cycle after a word is accepted and falls after the cycle of the last write-back. A word offered while busy is ignored.
- R8: A word with bit 31 set, with bits 29..28 = 3, or with bits 22..21 = 3 is rejected. It causes no busy and no write.
- R9: Reset clears every register and `busy`. A host write is applied only while the unit is not busy.
- R10: Register numbers A+i, B+i and D+i wrap modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction word offered |
| issue_word | input | 32 | Instruction word |
| busy | output | 1 | Instruction in progress |
| wb_valid | output | 1 | Write-back this cycle |
| wb_addr | output | 7 | Write-back register |
| wb_data | output | 32 | Write-back value |
| host_wr_en | input | 1 | Host register write |
| host_wr_addr | input | 7 | Host write register |
| host_wr_data | input | 32 | Host write value |
| host_rd_addr | input | 7 | Host read register |
| host_rd_data | output | 32 | Host read value (combinational) |

## Verification
The operands mix positive and negative values, upper halves that differ from the sign-extended lower halves, and values that sit just below a rounding step. These tell apart 16x16 from 32x16 products, signed from unsigned handling, and rounded from truncated results. Each product code is run with and without rounding, and each of the three forms is run with several counts. Separate runs use register 0 as a source and as the destination, use ranges that wrap past 127, offer words while busy, and send illegal codes. A bench model predicts the write-back, `busy` and the host read value on every cycle. A set of random words then mixes overlapping source and destination ranges.

// File: rtl/vmul_pkg.sv
// vmul_pkg: instruction fields, operation codes and decode helpers for the
// vector multiply unit. Assumes the 32-bit word layout given in the brief.
package vmul_pkg;
    localparam int REG_AW = 7;
    localparam int CNT_W  = 4;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_DOT  = 2'd1,
        OP_SAXP = 2'd2
    } vop_e;

    typedef struct packed {
        logic              wide;
        logic [4:0]        shift;
        logic              rnd;
        vop_e              op;
        logic [CNT_W-1:0]  cnt;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rb;
    } vinstr_t;

    // A word is executable only with a defined product code and operation.
    function automatic logic instr_legal(input logic [WORD_W-1:0] w);
        return !w[31] && (w[29:28] != 2'b11) && (w[22:21] != 2'b11);
    endfunction

    // Split a word into its fields; shift code n maps to 8*n bits.
    function automatic vinstr_t instr_decode(input logic [WORD_W-1:0] w);
        vinstr_t d;
        d.wide  = w[30];
        d.shift = {w[29:28], 3'b000};
        d.rnd   = w[23];
        d.op    = vop_e'(w[22:21]);
        d.cnt   = w[27:24];
        d.ra    = w[20:14];
        d.rd    = w[13:7];
        d.rb    = w[6:0];
        return d;
    endfunction
endpackage

// File: rtl/vmul_regfile.sv
// vmul_regfile: register array with one write port and NRD combinational read
// ports. Entry 0 reads as zero and ignores writes. Cleared by reset.
module vmul_regfile #(
    parameter int N   = 128,
    parameter int W   = 32,
    parameter int NRD = 4,
    localparam int AW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    logic [W-1:0] mem [N];

    // Storage update: clear on reset, otherwise write any entry but zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we && (waddr != '0)) begin
            mem[waddr] <= wdata;
        end
    end

    // Read ports, entry zero forced to zero.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : mem[raddr[g]];
    end
endmodule

// File: rtl/vmul_lane.sv
// vmul_lane: one signed product with right shift, optional round-to-nearest
// and an addend. Assumes shift is a multiple of 8 no larger than HW.
module vmul_lane #(
    parameter int W   = 32,
    localparam int HW = W / 2,
    localparam int PW = W + HW
) (
    input  logic         wide,
    input  logic [4:0]   shift,
    input  logic         rnd,
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic [W-1:0] addend,
    output logic [W-1:0] res
);
    logic signed [PW-1:0] pa, pm, prod, bias, shd;

    // Sign-extend operands, form product, round, shift, add.
    always_comb begin
        pa   = wide ? PW'(signed'(a)) : PW'(signed'(a[HW-1:0]));
        pm   = PW'(signed'(m[HW-1:0]));
        prod = pa * pm;
        bias = (rnd && (shift != 5'd0)) ? (PW'(1) << (shift - 5'd1)) : '0;
        shd  = (prod + bias) >>> shift;
        res  = shd[W-1:0] + addend;
    end
endmodule

// File: rtl/vmul_ctrl.sv
// vmul_ctrl: accepts legal words while idle, steps the element index, drives
// register addresses, write enable and the dot-product accumulator.
module vmul_ctrl
    import vmul_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = REG_AW,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [31:0]   issue_word,
    input  logic [W-1:0]  lane_res,
    output logic          busy,
    output vop_e          op,
    output logic          wide,
    output logic [4:0]    shift,
    output logic          rnd,
    output logic [AW-1:0] a_addr,
    output logic [AW-1:0] b_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  acc
);
    vinstr_t       ins_q;
    logic          busy_q;
    logic [CW-1:0] idx_q;
    logic [W-1:0]  acc_q;
    logic          last, accept;

    assign last   = (idx_q == ins_q.cnt);
    assign accept = issue_valid && !busy_q && instr_legal(issue_word);

    // Sequencing: latch word on accept, then one element per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            ins_q  <= '0;
            acc_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            ins_q  <= instr_decode(issue_word);
            acc_q  <= '0;
        end else if (busy_q) begin
            if (ins_q.op == OP_DOT) acc_q <= lane_res;
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_q + 1'b1;
        end
    end

    // Address generation and write enable for the current element.
    always_comb begin
        busy    = busy_q;
        op      = ins_q.op;
        wide    = ins_q.wide;
        shift   = ins_q.shift;
        rnd     = ins_q.rnd;
        acc     = acc_q;
        a_addr  = ins_q.ra + AW'(idx_q);
        b_addr  = ins_q.rb + AW'(idx_q);
        wr_addr = (ins_q.op == OP_DOT) ? ins_q.rd : ins_q.rd + AW'(idx_q);
        wr_en   = busy_q && ((ins_q.op != OP_DOT) || last);
    end

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !last |=> busy_q);
    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(issue_valid));
    // R8
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && issue_valid && !instr_legal(issue_word) |=> !busy_q);
    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !last |=> idx_q == $past(idx_q) + 1'b1);
    // R4
    dot_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (ins_q.op == OP_DOT) |=> acc_q == $past(lane_res));
endmodule

// File: rtl/vmul_unit.sv
// vmul_unit: top of the vector multiply unit. Connects sequencer, arithmetic
// lane and register file. Read ports: A element, B element, scalar register 1,
// host. Unit writes take the write port; host writes only while idle.
module vmul_unit
    import vmul_pkg::*;
#(
    parameter int N   = 128,
    parameter int W   = WORD_W,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [31:0]   issue_word,
    output logic          busy,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [W-1:0]  wb_data,
    input  logic          host_wr_en,
    input  logic [AW-1:0] host_wr_addr,
    input  logic [W-1:0]  host_wr_data,
    input  logic [AW-1:0] host_rd_addr,
    output logic [W-1:0]  host_rd_data
);
    localparam int NRD = 4;
    localparam logic [AW-1:0] SCALAR_REG = AW'(1);

    vop_e                  op;
    logic                  wide, rnd, u_we, rf_we;
    logic [4:0]            shift;
    logic [AW-1:0]         a_addr, b_addr, u_waddr, rf_waddr;
    logic [W-1:0]          acc, lane_res, lane_m, lane_add, rf_wdata;
    logic [NRD-1:0][AW-1:0] rd_addr;
    logic [NRD-1:0][W-1:0]  rd_data;

    vmul_ctrl #(.W(W), .AW(AW), .CW(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_word(issue_word), .lane_res(lane_res), .busy(busy), .op(op),
        .wide(wide), .shift(shift), .rnd(rnd), .a_addr(a_addr),
        .b_addr(b_addr), .wr_en(u_we), .wr_addr(u_waddr), .acc(acc)
    );

    // Operand selection: multiplier and addend depend on the form.
    always_comb begin
        lane_m   = (op == OP_SAXP) ? rd_data[2] : rd_data[1];
        unique case (op)
            OP_DOT:  lane_add = acc;
            OP_SAXP: lane_add = rd_data[1];
            default: lane_add = '0;
        endcase
    end

    vmul_lane #(.W(W)) u_lane (
        .wide(wide), .shift(shift), .rnd(rnd), .a(rd_data[0]), .m(lane_m),
        .addend(lane_add), .res(lane_res)
    );

    // Write-port arbitration: unit first, host only while idle.
    always_comb begin
        rd_addr[0] = a_addr;
        rd_addr[1] = b_addr;
        rd_addr[2] = SCALAR_REG;
        rd_addr[3] = host_rd_addr;
        rf_we      = u_we || (host_wr_en && !busy);
        rf_waddr   = u_we ? u_waddr  : host_wr_addr;
        rf_wdata   = u_we ? lane_res : host_wr_data;
    end

    vmul_regfile #(.N(N), .W(W), .NRD(NRD)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
        .wdata(rf_wdata), .raddr(rd_addr), .rdata(rd_data)
    );

    assign wb_valid     = u_we;
    assign wb_addr      = u_waddr;
    assign wb_data      = lane_res;
    assign host_rd_data = rd_data[3];

    // R9
    host_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !wb_valid |-> !rf_we);
endmodule

// File: tb/sim_vmul_unit.sv
module sim_vmul_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_word = '0;
    logic        busy, wb_valid;
    logic [6:0]  wb_addr;
    logic [31:0] wb_data;
    logic        host_wr_en = 1'b0;
    logic [6:0]  host_wr_addr = '0, host_rd_addr = '0;
    logic [31:0] host_wr_data = '0;
    logic [31:0] host_rd_data;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    string req = "R9";

    // reference model state
    int unsigned mem [128];
    bit m_busy;
    int m_idx, m_cnt, m_op, m_sh, m_a, m_b, m_d;
    bit m_wide, m_rnd;
    int m_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmul_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_word(issue_word), .busy(busy), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_data(wb_data), .host_wr_en(host_wr_en),
        .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data)
    );

    function automatic int unsigned rdm(int r);
        return (r % 128 == 0) ? 0 : mem[r % 128];
    endfunction

    // R1 R2: signed product, rounding bias, arithmetic shift, add
    function automatic int unsigned elem(bit wide, int sh, bit rnd,
                                         int unsigned a, int unsigned m,
                                         int unsigned add);
        longint pa, pm, p;
        pa = wide ? longint'(int'(a)) : longint'(shortint'(a[15:0]));
        pm = longint'(shortint'(m[15:0]));
        p  = pa * pm;
        if (rnd && sh > 0) p += longint'(1) << (sh - 1);
        p = p >>> sh;
        return int'(p[31:0]) + add;
    endfunction

    function automatic bit legal(logic [31:0] w);
        int t;
        t = int'(w[31:28]);
        return (t == 0 || t == 1 || t == 2 || t == 4 || t == 5 || t == 6)
               && w[22:21] != 2'd3;
    endfunction

    function automatic logic [31:0] mk(int t, int op, bit rnd, int cnt,
                                       int a, int d, int b);
        return {4'(t), 4'(cnt), rnd, 2'(op), 7'(a), 7'(d), 7'(b)};
    endfunction

    task automatic expect_now(output bit v, output int addr,
                              output int unsigned data);
        int unsigned av, bv, r;
        v = 0; addr = 0; data = 0;
        if (!m_busy) return;
        av = rdm(m_a + m_idx);
        bv = rdm(m_b + m_idx);
        case (m_op)
            0: r = elem(m_wide, m_sh, m_rnd, av, bv, 0);
            1: r = elem(m_wide, m_sh, m_rnd, av, bv, m_acc);
            default: r = elem(m_wide, m_sh, m_rnd, av, rdm(1), bv);
        endcase
        data = r;
        if (m_op == 1) begin
            v = (m_idx == m_cnt); addr = m_d;
        end else begin
            v = 1; addr = (m_d + m_idx) % 128;
        end
    endtask

    task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    // compare DUT with model, then advance model over the coming edge
    task automatic tick();
        bit v; int addr; int unsigned data;
        host_rd_addr = 7'(cyc * 37);
        #1;
        expect_now(v, addr, data);
        chk("busy", 32'(busy), 32'(m_busy));
        chk("wb_valid", 32'(wb_valid), 32'(v));
        if (v) begin
            chk("wb_addr", 32'(wb_addr), 32'(addr));
            chk("wb_data", wb_data, data);
        end
        chk("host_rd_data", host_rd_data, rdm(int'(host_rd_addr)));
        if (!rst_n) begin
            foreach (mem[i]) mem[i] = 0;
            m_busy = 0;
        end else if (m_busy) begin
            if (v && addr != 0) mem[addr] = data;
            if (m_op == 1) m_acc = int'(data);
            if (m_idx == m_cnt) m_busy = 0;
            else m_idx++;
        end else begin
            if (host_wr_en && host_wr_addr != 0)
                mem[host_wr_addr] = host_wr_data;
            if (issue_valid && legal(issue_word)) begin
                m_busy = 1; m_idx = 0; m_acc = 0;
                m_cnt  = int'(issue_word[27:24]);
                m_op   = int'(issue_word[22:21]);
                m_rnd  = issue_word[23];
                m_wide = issue_word[30];
                m_sh   = 8 * int'(issue_word[29:28]);
                m_a = int'(issue_word[20:14]);
                m_d = int'(issue_word[13:7]);
                m_b = int'(issue_word[6:0]);
            end
        end
        @(negedge clk);
    endtask

    task automatic hwrite(int a, int unsigned d);
        host_wr_en = 1; host_wr_addr = 7'(a); host_wr_data = d;
        tick();
        host_wr_en = 0;
    endtask

    task automatic run(logic [31:0] w);
        issue_valid = 1; issue_word = w;
        tick();
        issue_valid = 0;
        while (m_busy) tick();
        tick();
    endtask

    task automatic hread(int a, int unsigned exp);
        host_rd_addr = 7'(a);
        #1;
        chk("readback", host_rd_data, exp);
    endtask

    initial begin
        @(negedge clk);
        req = "R9 reset";
        repeat (3) tick();
        rst_n = 1;
        tick();
        hread(5, 0);

        req = "R9 load";
        for (int i = 1; i < 128; i++)
            hwrite(i, (i * 32'h9E3779B1) ^ ((i % 3 == 0) ? 32'h8000_0000 : 32'h0000_8000));
        hwrite(1, 32'h0001_FF80);
        hwrite(10, 32'h1234_00FF); hwrite(20, 32'hFFFF_0101);
        hwrite(11, 32'h0000_7FFF); hwrite(21, 32'h0000_7FFF);

        req = "R3 multiply";
        run(mk(0, 0, 0, 3, 10, 40, 20));
        run(mk(0, 0, 0, 0, 11, 41, 21));
        for (int t = 0; t < 7; t++) begin
            if (t == 3) continue;
            req = "R1 product type";
            run(mk(t, 0, 0, 2, 10 + t, 50, 20));
            req = "R2 rounding";
            run(mk(t, 0, 1, 2, 10 + t, 60, 20));
        end
        req = "R4 dot";
        run(mk(0, 1, 0, 3, 10, 70, 20));
        run(mk(5, 1, 1, 15, 30, 71, 90));
        run(mk(2, 1, 0, 0, 11, 72, 21));
        req = "R5 scaled add";
        run(mk(0, 2, 0, 3, 10, 80, 20));
        run(mk(6, 2, 1, 5, 30, 85, 40));

        req = "R6 register zero";
        run(mk(0, 0, 0, 1, 0, 0, 20));
        hwrite(0, 32'hDEAD_BEEF);
        hread(0, 0);
        run(mk(4, 2, 0, 1, 10, 90, 0));

        req = "R7 issue while busy";
        issue_valid = 1; issue_word = mk(0, 0, 0, 4, 10, 100, 20);
        tick();
        issue_word = mk(0, 0, 0, 0, 11, 100, 21);
        tick(); tick();
        issue_valid = 0;
        req = "R9 host write while busy";
        host_wr_en = 1; host_wr_addr = 7'd110; host_wr_data = 32'hCAFE_0001;
        tick();
        host_wr_en = 0;
        while (m_busy) tick();
        tick();
        hread(110, mem[110]);

        req = "R8 illegal codes";
        run(mk(3, 0, 0, 2, 10, 45, 20));
        run(mk(8, 0, 0, 2, 10, 45, 20));
        run(mk(7, 0, 0, 2, 10, 45, 20));
        run(mk(0, 3, 0, 2, 10, 45, 20));

        req = "R10 wrap";
        run(mk(1, 0, 1, 4, 126, 125, 127));
        run(mk(0, 2, 0, 3, 127, 2, 125));

        req = "R3 random mix";
        for (int k = 0; k < 60; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (k % 5 != 0) w[31] = 1'b0;
            run(w);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog got %0d exp %0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule